// File: doc/BRIEF.md
# Monitor Mode Entry Controller

This block decides, once per power-on, whether a small microcontroller starts in its serial monitor mode, and which clock and watchdog policy goes with that choice. It watches the reset pin, two qualified "test voltage present" flags (one for the IRQ pin and one for the reset pin), the IRQ pin logic level, a port pin that selects the clock divisor, and the two reset-vector bytes read from memory. On the first clock after power-on reset in which the reset pin is released, it latches the entry mode, the bus clock divisor select and the PLL request. It keeps them until the next power-on reset.

There are two ways in. If both vector bytes are erased, the block takes the blank-vector path. It issues an extra internal reset pulse, fixes the divisor at four, requests the PLL when the IRQ pin is low, and disables the watchdog for good. If the vector is programmed and high voltage is on the IRQ pin, the block takes the high-voltage path. The port pin then picks either the bypassed oscillator stage or divide-by-four. The watchdog stays disabled only while high voltage is held on the IRQ pin. Once high voltage has been seen on the reset pin, the watchdog stays disabled permanently.

Top module: `mon_entry_top`

## Requirements
- R1: The vector counts as blank only when both `vecHi` and `vecLo` equal 8'hFF. A non-blank vector captured with `irqHv` low gives normal start-up: `monFlag`=0, `divSel`=2'b10, `pllReq`=0, `wdDis`=0, and no extra reset.
- R2: High-voltage entry (non-blank vector, `irqHv`=1 at capture) with `selPin`=0 sets `divSel`=2'b01. This code means the oscillator halving stage is bypassed, so the bus runs at input/2.
- R3: High-voltage entry with `selPin`=1 sets `divSel`=2'b10, meaning the bus runs at input/4.
- R4: Blank-vector entry takes priority over high-voltage entry. It sets `divSel`=2'b10 whatever `selPin` is, and sets `pllReq`=1 exactly when `irqLvl` is 0 at capture.
- R5: After blank-vector entry, `extraRst` is high for exactly 16 consecutive clocks, starting the cycle after capture. It never rises on any other path.
- R6: On high-voltage entry, `monFlag` rises at the capture edge. On blank-vector entry, `monFlag` rises at the same edge where `extraRst` falls.
- R7: After blank-vector entry, `wdDis` is 1 from the second cycle after capture onward, whatever `irqHv` and `rstHv` do.
- R8: In high-voltage mode, `wdDis` equals (`irqHv` OR `rstHv`) of the previous clock, until high voltage has been seen on the reset pin.
- R9: Once `rstHv` is seen in high-voltage mode, `wdDis` stays 1 until the next power-on reset, even after `irqHv` is removed.
- R10: Capture happens on the first clock after `rstPor` in which `rstPinN` is high. Later changes to any input, including reset-pin pulses, leave `monFlag`, `divSel` and `pllReq` unchanged.
- R11: While `rstPor` is high, all outputs are cleared and `divSel` reads 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstPor | input | 1 | Synchronous power-on reset, active high |
| rstPinN | input | 1 | Reset pin level, low holds reset |
| irqHv | input | 1 | Qualified test voltage present on IRQ pin |
| rstHv | input | 1 | Qualified test voltage present on reset pin |
| irqLvl | input | 1 | IRQ pin logic level |
| selPin | input | 1 | Port pin choosing the divisor on high-voltage entry |
| vecHi | input | 8 | Reset vector high byte |
| vecLo | input | 8 | Reset vector low byte |
| monFlag | output | 1 | Monitor mode active |
| divSel | output | 2 | Bus divisor select: 01 bypass (in/2), 10 in/4 |
| pllReq | output | 1 | PLL enable request |
| wdDis | output | 1 | Watchdog disable |
| extraRst | output | 1 | Extra internal reset pulse |

## Verification
Entry is tried with programmed vectors, with a vector that has only one byte erased, and with a fully erased vector. These patterns separate the blank test from a single-byte match. High-voltage entry is run with the port pin at both levels to show the two divisor codes apart. Blank entry is run with the IRQ level at both values, and with high voltage present, to show the PLL request and the path priority. Watchdog runs drop the IRQ voltage with and without an earlier reset-pin voltage, which tells the held policy from the latched one. Delayed pin release and post-capture input churn show that only the first release is sampled.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_HV    = 2'd1,
    MODE_BLANK = 2'd2
  } entryMode_t;

  localparam logic [1:0] DIV_BYPASS = 2'b01;
  localparam logic [1:0] DIV_FOUR   = 2'b10;

  typedef struct packed {
    logic capture;
    logic monGo;
    logic pulseOn;
  } ctlStrobe_t;
endpackage

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int EXTRA_CYC = 16
) (
  input  logic       clk,
  input  logic       rstPor,
  input  logic       rstPinN,
  input  logic       vecBlank,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(EXTRA_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXTRA_CYC - 1);

  typedef enum logic [1:0] {ST_WAIT, ST_PULSE, ST_DONE} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rstPor) begin
      phase <= ST_WAIT;
      cnt   <= '0;
    end else begin
      case (phase)
        ST_WAIT: if (rstPinN) begin
          phase <= vecBlank ? ST_PULSE : ST_DONE;
          cnt   <= CNT_LOAD;
        end
        ST_PULSE: if (cnt == '0) phase <= ST_DONE;
                  else cnt <= cnt - 1'b1;
        default: phase <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (phase == ST_WAIT) && rstPinN;
    strobe.pulseOn = (phase == ST_PULSE);
    strobe.monGo   = (strobe.capture && !vecBlank) ||
                     ((phase == ST_PULSE) && (cnt == '0));
  end

  // Independent run-length counter for the pulse check
  logic [CNT_W:0] runLen;
  always_ff @(posedge clk) begin
    if (rstPor) runLen <= '0;
    else        runLen <= strobe.pulseOn ? runLen + 1'b1 : '0;
  end

  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (rstPor)
    (strobe.pulseOn && !$past(strobe.pulseOn)) |-> ($past(strobe.capture) && $past(vecBlank)));

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (rstPor)
    (!strobe.pulseOn && $past(strobe.pulseOn)) |-> (runLen == (CNT_W+1)'(EXTRA_CYC)));
endmodule

// File: rtl/mon_entry_dp.sv
module mon_entry_dp
  import mon_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstPor,
  input  ctlStrobe_t       strobe,
  input  logic [VEC_W-1:0] vecHi,
  input  logic [VEC_W-1:0] vecLo,
  input  logic             irqHv,
  input  logic             rstHv,
  input  logic             irqLvl,
  input  logic             selPin,
  output logic             vecBlank,
  output logic             monFlag,
  output logic [1:0]       divSel,
  output logic             pllReq,
  output logic             wdDis,
  output logic             extraRst
);
  entryMode_t modeQ, nextMode;
  logic [1:0] divQ, nextDiv;
  logic       pllQ, nextPll, monQ, seenQ, wdQ, wdNext;

  assign vecBlank = (&vecHi) && (&vecLo);

  always_comb begin
    nextMode = MODE_NONE;
    nextDiv  = DIV_FOUR;
    nextPll  = 1'b0;
    if (vecBlank) begin
      nextMode = MODE_BLANK;
      nextPll  = !irqLvl;
    end else if (irqHv) begin
      nextMode = MODE_HV;
      nextDiv  = selPin ? DIV_FOUR : DIV_BYPASS;
    end
  end

  assign wdNext = (modeQ == MODE_BLANK) ||
                  ((modeQ == MODE_HV) && (irqHv || rstHv || seenQ));

  always_ff @(posedge clk) begin
    if (rstPor) begin
      modeQ <= MODE_NONE;
      divQ  <= DIV_FOUR;
      pllQ  <= 1'b0;
      monQ  <= 1'b0;
      seenQ <= 1'b0;
      wdQ   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        modeQ <= nextMode;
        divQ  <= nextDiv;
        pllQ  <= nextPll;
      end
      if (strobe.monGo)
        monQ <= strobe.capture ? (nextMode != MODE_NONE) : (modeQ != MODE_NONE);
      seenQ <= seenQ || ((modeQ == MODE_HV) && rstHv);
      wdQ   <= wdNext;
    end
  end

  assign monFlag  = monQ;
  assign divSel   = divQ;
  assign pllReq   = pllQ;
  assign wdDis    = wdQ;
  assign extraRst = strobe.pulseOn;

  assert_hold_R10: assert property (@(posedge clk) disable iff (rstPor)
    !strobe.capture |=> ($stable(modeQ) && $stable(divQ) && $stable(pllQ)));

  assert_blank_wd_R7: assert property (@(posedge clk) disable iff (rstPor)
    (modeQ == MODE_BLANK && monQ) |-> wdQ);

  assert_pll_src_R4: assert property (@(posedge clk) disable iff (rstPor)
    pllQ |-> (modeQ == MODE_BLANK && divQ == DIV_FOUR));

  assert_mon_rise_R6: assert property (@(posedge clk) disable iff (rstPor)
    (monQ && !$past(monQ)) |-> ($past(strobe.capture) || $past(strobe.pulseOn)));

  assert_seen_sticky_R9: assert property (@(posedge clk) disable iff (rstPor)
    seenQ |=> wdQ);
endmodule

// File: rtl/mon_entry_top.sv
module mon_entry_top #(
  parameter int VEC_W     = 8,
  parameter int EXTRA_CYC = 16
) (
  input  logic             clk,
  input  logic             rstPor,
  input  logic             rstPinN,
  input  logic             irqHv,
  input  logic             rstHv,
  input  logic             irqLvl,
  input  logic             selPin,
  input  logic [VEC_W-1:0] vecHi,
  input  logic [VEC_W-1:0] vecLo,
  output logic             monFlag,
  output logic [1:0]       divSel,
  output logic             pllReq,
  output logic             wdDis,
  output logic             extraRst
);
  mon_entry_pkg::ctlStrobe_t strobe;
  logic vecBlank;

  mon_entry_ctrl #(.EXTRA_CYC(EXTRA_CYC)) u_ctrl (
    .clk(clk), .rstPor(rstPor), .rstPinN(rstPinN),
    .vecBlank(vecBlank), .strobe(strobe)
  );

  mon_entry_dp #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstPor(rstPor), .strobe(strobe),
    .vecHi(vecHi), .vecLo(vecLo), .irqHv(irqHv), .rstHv(rstHv),
    .irqLvl(irqLvl), .selPin(selPin), .vecBlank(vecBlank),
    .monFlag(monFlag), .divSel(divSel), .pllReq(pllReq),
    .wdDis(wdDis), .extraRst(extraRst)
  );
endmodule

// File: tb/mon_entry_top_tb.sv
`timescale 1ns/1ps
module mon_entry_top_tb;
  logic clk = 1'b0;
  logic rstPor = 1'b1, rstPinN = 1'b0, irqHv = 1'b0, rstHv = 1'b0;
  logic irqLvl = 1'b1, selPin = 1'b0;
  logic [7:0] vecHi = 8'h12, vecLo = 8'h34;
  logic monFlag, pllReq, wdDis, extraRst;
  logic [1:0] divSel;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mon_entry_top u_dut (
    .clk(clk), .rstPor(rstPor), .rstPinN(rstPinN), .irqHv(irqHv),
    .rstHv(rstHv), .irqLvl(irqLvl), .selPin(selPin), .vecHi(vecHi),
    .vecLo(vecLo), .monFlag(monFlag), .divSel(divSel), .pllReq(pllReq),
    .wdDis(wdDis), .extraRst(extraRst)
  );

  // Behavioural reference model, updated on every rising edge
  int  mMode = 0, mDiv = 2, mPulse = 0;
  bit  mDone = 0, mPll = 0, mMon = 0, mSeen = 0, mWd = 0;
  bit  cmpOn = 0;

  always @(posedge clk) begin
    if (rstPor) begin
      mDone = 0; mMode = 0; mDiv = 2; mPll = 0; mMon = 0;
      mPulse = 0; mSeen = 0; mWd = 0;
    end else begin
      bit blank;
      int oldMode;
      oldMode = mMode;
      mWd   = (oldMode == 2) || (oldMode == 1 && (irqHv || rstHv || mSeen));
      mSeen = mSeen || (oldMode == 1 && rstHv);
      blank = (vecHi == 8'hFF) && (vecLo == 8'hFF);
      if (!mDone && rstPinN) begin
        mDone = 1;
        if (blank) begin
          mMode = 2; mDiv = 2; mPll = !irqLvl; mPulse = 16;
        end else if (irqHv) begin
          mMode = 1; mDiv = selPin ? 2 : 1; mPll = 0; mMon = 1;
        end else begin
          mMode = 0; mDiv = 2; mPll = 0; mMon = 0;
        end
      end else if (mPulse > 0) begin
        mPulse = mPulse - 1;
        if (mPulse == 0) mMon = 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the model on each falling edge
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R6 monFlag",  int'(monFlag),  int'(mMon));
      chk("R2 divSel",   int'(divSel),   mDiv);
      chk("R4 pllReq",   int'(pllReq),   int'(mPll));
      chk("R8 wdDis",    int'(wdDis),    int'(mWd));
      chk("R5 extraRst", int'(extraRst), int'(mPulse > 0));
    end
  end

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic powerOn(logic [7:0] hi, logic [7:0] lo, logic hv, logic lvl, logic sel);
    @(negedge clk);
    rstPor = 1'b1; rstPinN = 1'b0; rstHv = 1'b0;
    waitN(2);
    vecHi = hi; vecLo = lo; irqHv = hv; irqLvl = lvl; selPin = sel;
    rstPor = 1'b0;
    @(negedge clk);
    rstPinN = 1'b1;
  endtask

  task automatic measurePulse(output int len);
    len = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (extraRst) len++;
    end
  endtask

  initial begin
    int plen;
    waitN(2);
    // R11: reset state
    chk("R11 monFlag", int'(monFlag), 0);
    chk("R11 divSel",  int'(divSel),  2);
    chk("R11 pllReq",  int'(pllReq),  0);
    chk("R11 wdDis",   int'(wdDis),   0);
    chk("R11 extraRst", int'(extraRst), 0);
    cmpOn = 1;

    // R1: programmed vector, no high voltage
    powerOn(8'h12, 8'h34, 1'b0, 1'b1, 1'b0);
    waitN(4);
    chk("R1 normal monFlag", int'(monFlag), 0);
    chk("R1 normal divSel",  int'(divSel),  2);

    // R1: only one byte erased is not blank
    powerOn(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
    measurePulse(plen);
    chk("R1 half erased pulse", plen, 0);
    chk("R1 half erased monFlag", int'(monFlag), 0);

    // R2 and R8: high voltage, port pin low, then voltage removed
    powerOn(8'h00, 8'h80, 1'b1, 1'b1, 1'b0);
    waitN(3);
    chk("R2 bypass divSel", int'(divSel), 1);
    chk("R6 hv monFlag",    int'(monFlag), 1);
    chk("R8 wd held",       int'(wdDis),  1);
    irqHv = 1'b0;
    waitN(2);
    chk("R8 wd released",   int'(wdDis),  0);

    // R3 and R9: port pin high, reset-pin voltage latches watchdog disable
    powerOn(8'h5A, 8'hA5, 1'b1, 1'b1, 1'b1);
    waitN(3);
    chk("R3 div4 divSel", int'(divSel), 2);
    rstHv = 1'b1;
    @(negedge clk);
    rstHv = 1'b0; irqHv = 1'b0;
    waitN(4);
    chk("R9 wd latched", int'(wdDis), 1);

    // R4, R5, R6, R7: blank vector, IRQ high, pin toggles
    powerOn(8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1);
    measurePulse(plen);
    chk("R5 pulse length", plen, 16);
    chk("R4 no pll", int'(pllReq), 0);
    chk("R4 blank div4", int'(divSel), 2);
    chk("R6 blank monFlag", int'(monFlag), 1);
    irqHv = 1'b1; waitN(2); irqHv = 1'b0; rstHv = 1'b1; waitN(2); rstHv = 1'b0;
    waitN(2);
    chk("R7 blank wd", int'(wdDis), 1);

    // R4: blank priority over high voltage, PLL on IRQ low
    powerOn(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
    waitN(3);
    chk("R4 pll request", int'(pllReq), 1);
    chk("R4 priority div", int'(divSel), 2);
    chk("R5 priority pulse", int'(extraRst), 1);

    // R10: input churn and pin reset after capture
    waitN(20);
    vecHi = 8'h00; irqLvl = 1'b1; selPin = 1'b1; irqHv = 1'b0;
    rstPinN = 1'b0; waitN(3); rstPinN = 1'b1; waitN(3);
    chk("R10 held pll", int'(pllReq), 1);
    chk("R10 held mon", int'(monFlag), 1);
    chk("R10 no second pulse", int'(extraRst), 0);

    // R10: capture waits for the pin release
    @(negedge clk);
    rstPor = 1'b1; rstPinN = 1'b0;
    waitN(2);
    rstPor = 1'b0; vecHi = 8'hFF; vecLo = 8'hFF; irqLvl = 1'b0;
    waitN(5);
    vecLo = 8'h01; irqHv = 1'b1; selPin = 1'b0;
    @(negedge clk);
    rstPinN = 1'b1;
    waitN(3);
    chk("R10 late capture div", int'(divSel), 1);
    chk("R10 late capture pll", int'(pllReq), 0);

    waitN(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule